// File: doc/BRIEF.md
# Alias-tagged write-back cache

This block is a small write-back data cache whose entries can each answer to two line addresses at once. Every entry keeps a primary tag and an optional second tag, and both name the same 128-bit data line, so a read or write that matches either tag lands on the same contents. A line copy request from source line L to destination line M does not move data. The cache makes sure L is fully present, drops any stale entry for M, and records M as the second tag of L's entry. A later write to either name of a shared line first splits the line into a private entry for the written name. That makes copy-on-write happen inside the cache.

Both tags of an entry may have any value, so a set index taken from low address bits cannot work. Every tag of all eight entries is therefore compared in parallel. Requests use a valid/ready handshake. `req_ready` is high only while the cache is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester holds the request fields stable until then. Each accepted request ends with a one-cycle `rsp_valid` pulse, and there is no back-pressure on responses.

The memory side is a single line-wide request channel with a valid/ready handshake, plus a read-return strobe. The cache holds address, direction, data and mask stable while `mem_req_valid` is high and `mem_req_ready` is low. Write requests need no reply. Each read request is answered later by one `mem_rsp_valid` cycle that carries the whole line.

Top module: `alias_cache`

## Requirements
- R1: A read whose tag matches either tag of a resident entry, on a word marked valid, returns that word in a one-cycle `rsp_valid` pulse without any memory request. `req_op` encodes 0 = read, 1 = word write, 2 (or 3) = line copy from `req_addr` to `req_dst`. Bits [31:4] of an address select the line and bits [3:2] select the 32-bit word. Word w of a line travels at bits [32w+31:32w] of the memory data buses.
- R2: Writes update only the cache. A dirty line reaches memory only when its entry is evicted. The memory write then carries only the words marked valid, as `mem_req_wmask` bit w for word w.
- R3: A write that misses allocates an entry without reading memory. Only the written word becomes valid, so its later write-back mask has a single bit set.
- R4: A read of a word marked invalid in a resident entry fetches the line and merges the returned data only into invalid words. Words already written keep their values.
- R5: After a copy from L to M, reads of M return L's data. When L's line is already fully valid and M is not resident, the copy makes no memory request. No line address is ever held by more than one tag in the array.
- R6: A copy whose source line is absent or only partly valid first fetches the source line. An entry carrying a second tag is always fully valid.
- R7: A copy onto a destination that already has its own entry discards that entry's data, even if dirty. Later reads of the destination return the copied data, and the discarded data is never written back.
- R8: A copy from a line whose entry already carries a second tag moves the old second tag to a fresh entry with the same data. After that, all three line addresses read the same contents.
- R9: A write to either name of a shared line changes only that name. The other name keeps the contents it had before the write.
- R10: Evicting a dirty entry with two tags writes its line to memory twice, primary address first and second-tag address on the very next memory write.
- R11: Victims are picked round-robin over all entries, never the entry holding the current request's hit. Eight lines whose low address bits are equal can all be resident together.
- R12: `req_ready` is high after reset and drops for the cycle after each accepted request. `mem_req_valid` stays high with stable address and direction until `mem_req_ready` is seen.
- R13: A copy whose destination equals its source, or is already the second tag of the source entry, completes with no memory traffic and no change to the data read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 copy |
| req_addr | input | 32 | Read/write address, or copy source |
| req_dst | input | 32 | Copy destination (line-aligned use) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Write-back line |
| mem_req_wmask | output | 4 | Per-word write enables |
| mem_rsp_valid | input | 1 | Read return strobe |
| mem_rsp_rdata | input | 128 | Returned line |

## Verification
The bench writes into one name of a shared line and reads the other name. A design that wrote in place without splitting would show the new value through both names. It copies onto a destination that holds a dirty partial line, so a design that kept the old entry would return the stale word or later write it back over the copied data. It forces evictions of a line with two tags and of a line with one written word, while the memory stalls its ready pseudo-randomly. The bench then checks write order, masks and final memory contents, so a design that wrote back only one name, fetched on a write miss, or overwrote written words during a fill would leave wrong values or extra traffic. It also counts memory reads across copies of resident lines, self-copies and repeated copies, where any memory access is an error.

// File: rtl/alias_cache_pkg.sv
package alias_cache_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_COPY  = 2'd2
  } cache_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_EVICT,
    S_WB_P,
    S_WB_A,
    S_POST,
    S_FILL,
    S_FILL_WAIT
  } cache_state_e;

  // Outcome of one pass through the decide state
  typedef enum logic [3:0] {
    D_READ,
    D_WRITE,
    D_DONE,
    D_FILL,
    D_DROP_B,
    D_LINK,
    D_INSTALL,
    D_SPLIT,
    D_DUP
  } cache_dec_e;

endpackage

// File: rtl/alias_cache_match.sv
module alias_cache_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 28,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            pv,
  input  logic [ENTRIES-1:0]            av,
  input  logic [ENTRIES-1:0][TAG_W-1:0] ptag,
  input  logic [ENTRIES-1:0][TAG_W-1:0] atag,
  input  logic [TAG_W-1:0]              tag,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx,
  output logic                          on_alias
);

  logic [ENTRIES-1:0] hit_p;
  logic [ENTRIES-1:0] hit_s;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_p[i] = pv[i] && (ptag[i] == tag);
    assign hit_s[i] = av[i] && (atag[i] == tag);
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    on_alias = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_p[i] || hit_s[i]) begin
        hit      = 1'b1;
        idx      = IDX_W'(i);
        on_alias = hit_s[i];
      end
    end
  end

endmodule

// File: rtl/alias_cache_victim.sv
module alias_cache_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             protect_en,
  input  logic [IDX_W-1:0] protect_idx,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0] ptr;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(ENTRIES - 1)) ? '0 : i + 1'b1;
  endfunction

  assign victim = (protect_en && (ptr == protect_idx)) ? step(ptr) : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= step(victim);
  end

endmodule

// File: rtl/alias_cache.sv
module alias_cache
  import alias_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ENTRIES    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [ADDR_W-1:0]            req_dst,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_rdata,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_we,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [WORD_W*LINE_WORDS-1:0] mem_req_wdata,
  output logic [LINE_WORDS-1:0]        mem_req_wmask,
  input  logic                         mem_rsp_valid,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_rsp_rdata
);

  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int BOFF_W = OFF_W - WIDX_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);

  // Entry array
  logic [ENTRIES-1:0]                              pv, av, dirty;
  logic [ENTRIES-1:0][TAG_W-1:0]                   ptag, atag;
  logic [ENTRIES-1:0][LINE_WORDS-1:0]              wv;
  logic [ENTRIES-1:0][LINE_WORDS-1:0][WORD_W-1:0]  data;

  // Captured request and work registers
  cache_state_e      state;
  cache_op_e         op_q;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic [WIDX_W-1:0] widx_q;
  logic [WORD_W-1:0] wdata_q;
  logic [IDX_W-1:0]  cur, vic;
  logic              cur_alias;
  cache_dec_e        post_q, dec;

  logic              hit_a, hit_b, alias_a, alias_b, take_victim;
  logic [IDX_W-1:0]  idx_a, idx_b, victim;
  logic              unused_low;

  assign unused_low = ^{req_addr[BOFF_W-1:0], req_dst[OFF_W-1:0]};

  alias_cache_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match_a (
    .pv(pv), .av(av), .ptag(ptag), .atag(atag), .tag(tag_a),
    .hit(hit_a), .idx(idx_a), .on_alias(alias_a)
  );

  alias_cache_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match_b (
    .pv(pv), .av(av), .ptag(ptag), .atag(atag), .tag(tag_b),
    .hit(hit_b), .idx(idx_b), .on_alias(alias_b)
  );

  alias_cache_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .protect_en(hit_a), .protect_idx(idx_a),
    .advance(take_victim), .victim(victim)
  );

  // What the decide state does this cycle
  always_comb begin
    unique case (op_q)
      OP_READ:  dec = !hit_a ? D_INSTALL : (!wv[idx_a][widx_q] ? D_FILL : D_READ);
      OP_WRITE: dec = !hit_a ? D_INSTALL : (av[idx_a] ? D_SPLIT : D_WRITE);
      default: begin
        if (tag_a == tag_b)                 dec = D_DONE;
        else if (!hit_a)                    dec = D_INSTALL;
        else if (!(&wv[idx_a]))             dec = D_FILL;
        else if (hit_b && (idx_b == idx_a)) dec = D_DONE;
        else if (hit_b)                     dec = D_DROP_B;
        else if (av[idx_a])                 dec = D_DUP;
        else                                dec = D_LINK;
      end
    endcase
  end

  assign take_victim = (state == S_DECIDE) &&
                       (dec == D_INSTALL || dec == D_SPLIT || dec == D_DUP);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_WB_P) || (state == S_WB_A) || (state == S_FILL);
  assign mem_req_we    = (state != S_FILL);
  assign mem_req_wdata = data[vic];
  assign mem_req_wmask = wv[vic];

  always_comb begin
    unique case (state)
      S_WB_P:  mem_req_addr = {ptag[vic], {OFF_W{1'b0}}};
      S_WB_A:  mem_req_addr = {atag[vic], {OFF_W{1'b0}}};
      default: mem_req_addr = {tag_a, {OFF_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pv        <= '0;
      av        <= '0;
      dirty     <= '0;
      wv        <= '0;
      ptag      <= '0;
      atag      <= '0;
      data      <= '0;
      op_q      <= OP_READ;
      tag_a     <= '0;
      tag_b     <= '0;
      widx_q    <= '0;
      wdata_q   <= '0;
      cur       <= '0;
      vic       <= '0;
      cur_alias <= 1'b0;
      post_q    <= D_INSTALL;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= cache_op_e'(req_op);
          tag_a   <= req_addr[ADDR_W-1:OFF_W];
          tag_b   <= req_dst[ADDR_W-1:OFF_W];
          widx_q  <= req_addr[OFF_W-1:BOFF_W];
          wdata_q <= req_wdata;
          state   <= S_DECIDE;
        end

        S_DECIDE: begin
          unique case (dec)
            D_READ: begin
              rsp_valid <= 1'b1;
              rsp_rdata <= data[idx_a][widx_q];
              state     <= S_IDLE;
            end
            D_WRITE: begin
              data[idx_a][widx_q] <= wdata_q;
              wv[idx_a][widx_q]   <= 1'b1;
              dirty[idx_a]        <= 1'b1;
              rsp_valid           <= 1'b1;
              state               <= S_IDLE;
            end
            D_DONE: begin
              rsp_valid <= 1'b1;
              state     <= S_IDLE;
            end
            D_FILL: begin
              cur   <= idx_a;
              state <= S_FILL;
            end
            D_DROP_B: begin
              // destination name is overwritten by the copy: forget it
              if (alias_b) begin
                av[idx_b] <= 1'b0;
              end else if (av[idx_b]) begin
                ptag[idx_b] <= atag[idx_b];
                av[idx_b]   <= 1'b0;
              end else begin
                pv[idx_b]    <= 1'b0;
                wv[idx_b]    <= '0;
                dirty[idx_b] <= 1'b0;
              end
            end
            D_LINK: begin
              atag[idx_a]  <= tag_b;
              av[idx_a]    <= 1'b1;
              dirty[idx_a] <= 1'b1;
              rsp_valid    <= 1'b1;
              state        <= S_IDLE;
            end
            default: begin
              vic       <= victim;
              cur       <= idx_a;
              cur_alias <= alias_a;
              post_q    <= dec;
              state     <= S_EVICT;
            end
          endcase
        end

        S_EVICT: state <= (pv[vic] && dirty[vic]) ? S_WB_P : S_POST;

        S_WB_P: if (mem_req_ready) state <= av[vic] ? S_WB_A : S_POST;

        S_WB_A: if (mem_req_ready) state <= S_POST;

        S_POST: begin
          state   <= S_DECIDE;
          pv[vic] <= 1'b1;
          av[vic] <= 1'b0;
          unique case (post_q)
            D_SPLIT: begin
              ptag[vic]  <= tag_a;
              wv[vic]    <= wv[cur];
              dirty[vic] <= dirty[cur];
              data[vic]  <= data[cur];
              av[cur]    <= 1'b0;
              if (!cur_alias) ptag[cur] <= atag[cur];
            end
            D_DUP: begin
              ptag[vic]  <= atag[cur];
              wv[vic]    <= wv[cur];
              dirty[vic] <= dirty[cur];
              data[vic]  <= data[cur];
              av[cur]    <= 1'b0;
            end
            default: begin
              ptag[vic]  <= tag_a;
              wv[vic]    <= '0;
              dirty[vic] <= 1'b0;
            end
          endcase
        end

        S_FILL: if (mem_req_ready) state <= S_FILL_WAIT;

        S_FILL_WAIT: if (mem_rsp_valid) begin
          for (int w = 0; w < LINE_WORDS; w++) begin
            if (!wv[cur][w]) data[cur][w] <= mem_rsp_rdata[w*WORD_W +: WORD_W];
          end
          wv[cur] <= '1;
          state   <= S_DECIDE;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alias_cache_checker.sv
module alias_cache_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ENTRIES    = 8,
  parameter int TAG_W      = 28
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            rsp_valid,
  input logic                            mem_req_valid,
  input logic                            mem_req_ready,
  input logic                            mem_req_we,
  input logic [ADDR_W-1:0]               mem_req_addr,
  input logic [ENTRIES-1:0]              pv,
  input logic [ENTRIES-1:0]              av,
  input logic [ENTRIES-1:0][TAG_W-1:0]   ptag,
  input logic [ENTRIES-1:0][TAG_W-1:0]   atag,
  input logic [ENTRIES-1:0][LINE_WORDS-1:0] wv
);

  logic dup_tag, bad_alias;

  always_comb begin
    dup_tag   = 1'b0;
    bad_alias = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pv[i] && av[i] && ptag[i] == atag[i]) dup_tag = 1'b1;
      if (av[i] && (!pv[i] || !(&wv[i])))     bad_alias = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++) begin
        if (pv[i] && pv[j] && ptag[i] == ptag[j]) dup_tag = 1'b1;
        if (pv[i] && av[j] && ptag[i] == atag[j]) dup_tag = 1'b1;
        if (av[i] && pv[j] && atag[i] == ptag[j]) dup_tag = 1'b1;
        if (av[i] && av[j] && atag[i] == atag[j]) dup_tag = 1'b1;
      end
    end
  end

  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_tag);

  p_alias_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_alias);

endmodule

bind alias_cache alias_cache_checker #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .ENTRIES(ENTRIES), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .pv(pv), .av(av), .ptag(ptag), .atag(atag), .wv(wv)
);

// File: tb/alias_cache_test.sv
module alias_cache_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'd0;
  logic [31:0]  req_addr = '0, req_dst = '0, req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_we;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic [3:0]   mem_req_wmask;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  alias_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_dst(req_dst), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_wmask(mem_req_wmask),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] refm [logic [31:0]];
  logic [31:0] memm [logic [31:0]];
  logic [31:0] wb_addr [$];
  logic [3:0]  wb_mask [$];
  bit          q_chk [$];
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic [31:0] scratch = 32'h00F0_0000;

  function automatic logic [31:0] seed(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed(a);
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return memm.exists(a) ? memm[a] : seed(a);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: push the expectation, then hand the request over
  task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                      input logic [31:0] wd, input bit chk, input logic [31:0] exp,
                      input string tag);
    q_chk.push_back(chk); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_dst = d; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q_chk.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    send(2'd0, a, 32'h0, 32'h0, 1'b1, ref_rd(a), tag);
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    refm[a] = d;
    send(2'd1, a, 32'h0, d, 1'b0, 32'h0, tag);
  endtask
  task automatic cp(input logic [31:0] l, input logic [31:0] m, input string tag);
    logic [31:0] tmp [4];
    for (int w = 0; w < 4; w++) tmp[w] = ref_rd(l + 32'(4*w));
    for (int w = 0; w < 4; w++) refm[m + 32'(4*w)] = tmp[w];
    send(2'd2, l, m, 32'h0, 1'b0, 32'h0, tag);
  endtask
  task automatic flush();
    for (int k = 0; k < 8; k++) begin
      rd(scratch, "R11 flush read");
      scratch = scratch + 32'h10;
    end
  endtask

  // Monitor: compare each response against the queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_chk.size() == 0) check(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
      else begin
        if (q_chk[0]) check(rsp_rdata == q_exp[0], q_tag[0], rsp_rdata, q_exp[0]);
        void'(q_chk.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  // Memory model with pseudo-random ready stalls
  initial begin
    logic [7:0] lfsr = 8'hA7;
    bit pend = 1'b0;
    logic [31:0] pend_a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        for (int w = 0; w < 4; w++) mem_rsp_rdata[w*32 +: 32] = mem_rd(pend_a + 32'(4*w));
        mem_rsp_valid = 1'b1;
        pend = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[3];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          wr_cnt++;
          wb_addr.push_back(mem_req_addr); wb_mask.push_back(mem_req_wmask);
          for (int w = 0; w < 4; w++)
            if (mem_req_wmask[w]) memm[mem_req_addr + 32'(4*w)] = mem_req_wdata[w*32 +: 32];
        end else begin
          rd_cnt++;
          pend = 1'b1;
          pend_a = mem_req_addr;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_1000, C = 32'h0000_3000;
  localparam logic [31:0] L = 32'h0000_5000, M = 32'h0000_6000, N = 32'h0000_7000;
  localparam logic [31:0] P = 32'h0000_8000, Q = 32'h0000_9000, S = 32'h0000_A000;

  initial begin
    int r0, w0, ip, in_;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R12 reset state",
          {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    // R3 / R2: write miss fetches nothing, writes nothing
    r0 = rd_cnt; w0 = wr_cnt;
    wr(A + 4, 32'h1111_1111, "R3 write miss");
    check(rd_cnt == r0, "R3 no fetch on write miss", 32'(rd_cnt - r0), 0);
    check(wr_cnt == w0, "R2 no memory write on cache write", 32'(wr_cnt - w0), 0);
    r0 = rd_cnt;
    rd(A + 4, "R1 read hit of written word");
    check(rd_cnt == r0, "R1 hit needs no memory", 32'(rd_cnt - r0), 0);
    // R4: invalid word read fills, written word survives
    rd(A + 8, "R4 fill of invalid word");
    check(rd_cnt == r0 + 1, "R4 one line fetch", 32'(rd_cnt - r0), 1);
    rd(A + 4, "R4 written word kept after fill");

    // R3: single word write-back mask
    wr(C, 32'hC0C0_C0C0, "R3 write miss second line");
    wb_addr.delete(); wb_mask.delete();
    flush();
    ok = 1'b0;
    foreach (wb_addr[i]) if (wb_addr[i] == C) ok = (wb_mask[i] == 4'b0001);
    check(ok, "R3 mask of single written word", 32'(ok), 1);
    check(mem_rd(C) == 32'hC0C0_C0C0, "R2 evicted word in memory", mem_rd(C), 32'hC0C0_C0C0);
    check(mem_rd(C + 4) == seed(C + 4), "R3 unwritten word untouched", mem_rd(C + 4), seed(C + 4));
    check(mem_rd(A + 4) == 32'h1111_1111, "R2 dirty line written back", mem_rd(A + 4), 32'h1111_1111);

    // R11: eight lines with equal low bits stay resident together
    for (int k = 1; k <= 8; k++) rd(32'(k) << 16, "R11 fill same-low-bit lines");
    r0 = rd_cnt;
    for (int k = 1; k <= 8; k++) rd(32'(k) << 16, "R11 re-read same-low-bit lines");
    check(rd_cnt == r0, "R11 all eight resident", 32'(rd_cnt - r0), 0);

    // R6 / R5: copy from absent source, then reads of destination
    r0 = rd_cnt;
    cp(L, M, "R6 copy from absent source");
    check(rd_cnt == r0 + 1, "R6 source fetched once", 32'(rd_cnt - r0), 1);
    r0 = rd_cnt; w0 = wr_cnt;
    rd(M, "R5 destination word 0");
    rd(M + 12, "R5 destination word 3");
    check(rd_cnt == r0 && wr_cnt == w0, "R5 destination hits with no traffic",
          32'(rd_cnt - r0 + wr_cnt - w0), 0);

    // R9: write to one name splits the line
    wr(M + 4, 32'hBEEF_0004, "R9 write to shared name");
    rd(L + 4, "R9 other name keeps old data");
    rd(M + 4, "R9 written name sees new data");
    rd(M, "R9 written name keeps rest of line");

    // R7: copy over a dirty partial destination entry
    wr(N, 32'h7777_7777, "R7 dirty destination");
    cp(L, N, "R7 copy onto resident destination");
    rd(N, "R7 destination reads copied data");
    wb_addr.delete(); wb_mask.delete();
    flush();
    ip = -1; in_ = -1; ok = 1'b1;
    foreach (wb_addr[i]) begin
      if (wb_addr[i] == L) ip = i;
      if (wb_addr[i] == N) begin in_ = i; if (wb_mask[i] != 4'hF) ok = 1'b0; end
    end
    check(ok, "R7 discarded partial line never written", 32'(ok), 1);
    check(ip >= 0 && in_ == ip + 1, "R10 primary then second name written back",
          32'(in_ - ip), 1);
    check(mem_rd(N) == seed(L), "R10 second name contents in memory", mem_rd(N), seed(L));
    check(mem_rd(M + 4) == 32'hBEEF_0004, "R9 split line written back",
          mem_rd(M + 4), 32'hBEEF_0004);

    // R8: copy from an entry whose second tag is taken
    cp(P, Q, "R8 first copy");
    cp(P, S, "R8 second copy forces duplicate");
    rd(P + 8, "R8 source reads");
    rd(Q + 8, "R8 older destination reads");
    rd(S + 8, "R8 newer destination reads");
    wr(Q + 8, 32'h9999_9999, "R8 write older destination");
    rd(S + 8, "R8 newer destination unaffected");
    rd(P + 8, "R8 source unaffected");
    rd(Q + 8, "R8 older destination updated");

    // R13: trivial copies
    r0 = rd_cnt; w0 = wr_cnt;
    cp(P, P, "R13 self copy");
    cp(P, S, "R13 repeat copy");
    check(rd_cnt == r0 && wr_cnt == w0, "R13 no traffic on trivial copies",
          32'(rd_cnt - r0 + wr_cnt - w0), 0);
    rd(S, "R13 data unchanged");
    rd(P + 12, "R13 source unchanged");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule